// File: doc/BRIEF.md
# Flash Byte-Program Host Controller

This controller sits on the host side of a parallel NOR flash and stores one byte per request. A single-cycle start pulse hands it a target address and a data byte. It first reads the current byte at that address. If the new value would need any bit to change from 0 to 1, it refuses the request. Otherwise it issues the four-write command sequence that starts an internal program operation.

While the device works, the controller reads the same address again and again. It watches bit 7 until that bit equals bit 7 of the byte being written. It then does one last full-byte read to confirm the result. It ends with a one-clock done pulse or a one-clock error pulse that carries a reason code.

If bit 7 never matches within a set number of reads, the controller writes the reset command F0h to the target and reports a timeout. Every flash cycle comes from one shared bus engine. That engine keeps the address stable before the write strobe falls and keeps the data driven after it rises.

Top module: `fbp_ctrl`

## Requirements
- R1: After reset the controller is idle. busy_o, done_o and err_o are 0, f_ce_n_o, f_we_n_o and f_oe_n_o are 1, and f_dq_oe_o is 0.
- R2: An accepted request writes exactly four bus cycles, in this order. First AAh to address 555h, then 55h to address 2AAh, then A0h to address 555h, then the data byte to the target address. The command addresses are zero above bit 11.
- R3: In every write cycle the address is driven SETUP_CYC clocks before the write strobe falls. Chip enable and write enable are both low for exactly STROBE_CYC clocks. The data stays driven, with the same value, for HOLD_CYC clocks after the write strobe rises.
- R4: Every read issued for a request targets the request's own address. Status reads repeat until read bit 7 equals bit 7 of the data.
- R5: When bit 7 matches, one more read of the full byte follows. If it equals the data, done_o pulses for one clock and err_code_o is 0.
- R6: If that confirming read differs from the data, err_o pulses with err_code_o = 3.
- R7: With PRE_READ = 1, the controller reads the target first. If (old AND new) differs from new, err_o pulses with err_code_o = 1 and no write cycle is issued.
- R8: After POLL_LIMIT status reads without a bit 7 match, the controller writes F0h to the target address. err_o then pulses with err_code_o = 2.
- R9: A start pulse while busy_o is 1 is ignored. The operation in progress keeps its address and data, and no second completion follows.
- R10: busy_o is 1 from the clock after an accepted start until the cycle in which done_o or err_o pulses. It is 0 in that cycle. done_o and err_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, sampled while idle |
| addr_i | input | ADDR_W | Target byte address |
| data_i | input | 8 | Byte to store |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock success pulse |
| err_o | output | 1 | One-clock failure pulse |
| err_code_o | output | 2 | Failure reason: 1 overwrite, 2 timeout, 3 confirm mismatch |
| f_addr_o | output | ADDR_W | Flash address bus |
| f_dq_o | output | 8 | Flash data to device |
| f_dq_oe_o | output | 1 | Data bus drive enable |
| f_dq_i | input | 8 | Flash data from device |
| f_ce_n_o | output | 1 | Chip enable, active low |
| f_we_n_o | output | 1 | Write enable, active low |
| f_oe_n_o | output | 1 | Output enable, active low |

## Verification
The embedded assertions watch the flash strobes on every clock. They check that the address holds across the write-strobe fall, that the data holds across its rise, and that write and output enable never overlap. They also check that the bus engine only takes a request while idle, that the poll counter stays under its limit, and that the captured target holds while busy.

The command order, the poll-read count, the overwrite refusal, the timeout recovery write and the confirm mismatch all depend on how the device answers. Only the bench's scenarios show these. They run against a behavioural flash model that can be made slow, stuck or faulty.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_OVERWRITE = 2'd1,
        ERR_TIMEOUT   = 2'd2,
        ERR_VERIFY    = 2'd3
    } err_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PRE   = 3'd1,
        S_CMD   = 3'd2,
        S_POLL  = 3'd3,
        S_CONF  = 3'd4,
        S_ABORT = 3'd5
    } seq_e;

    typedef enum logic [1:0] {
        B_IDLE   = 2'd0,
        B_SETUP  = 2'd1,
        B_STROBE = 2'd2,
        B_HOLD   = 2'd3
    } bus_e;

    localparam logic [11:0] UNLOCK_A_ADDR = 12'h555;
    localparam logic [11:0] UNLOCK_B_ADDR = 12'h2AA;
    localparam logic [7:0]  UNLOCK_A_DATA = 8'hAA;
    localparam logic [7:0]  UNLOCK_B_DATA = 8'h55;
    localparam logic [7:0]  PROG_SETUP    = 8'hA0;
    localparam logic [7:0]  RESET_CMD     = 8'hF0;

endpackage

// File: rtl/fbp_cmd_table.sv
module fbp_cmd_table
    import fbp_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [1:0]        step_i,
    input  logic [ADDR_W-1:0] tgt_addr_i,
    input  logic [7:0]        tgt_data_i,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [7:0]        cmd_data_o
);
    localparam int PAD_W = ADDR_W - 12;

    always_comb begin
        case (step_i)
            2'd0: begin
                cmd_addr_o = {{PAD_W{1'b0}}, UNLOCK_A_ADDR};
                cmd_data_o = UNLOCK_A_DATA;
            end
            2'd1: begin
                cmd_addr_o = {{PAD_W{1'b0}}, UNLOCK_B_ADDR};
                cmd_data_o = UNLOCK_B_DATA;
            end
            2'd2: begin
                cmd_addr_o = {{PAD_W{1'b0}}, UNLOCK_A_ADDR};
                cmd_data_o = PROG_SETUP;
            end
            default: begin
                cmd_addr_o = tgt_addr_i;
                cmd_data_o = tgt_data_i;
            end
        endcase
    end
endmodule

// File: rtl/fbp_bus_engine.sv
module fbp_bus_engine
    import fbp_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1,
    parameter int READ_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_wr_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [7:0]        req_data_i,
    output logic              ack_o,
    output logic [7:0]        rdata_o,
    output logic [ADDR_W-1:0] f_addr_o,
    output logic [7:0]        f_dq_o,
    output logic              f_dq_oe_o,
    input  logic [7:0]        f_dq_i,
    output logic              f_ce_n_o,
    output logic              f_we_n_o,
    output logic              f_oe_n_o
);
    localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_CD = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
    localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXC + 1);

    typedef struct packed {
        bus_e              st;
        logic [CW-1:0]     cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        dq;
        logic              dq_oe;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic [7:0]        rdata;
        logic              ack;
    } eng_t;

    eng_t q, n;

    always_comb begin
        n     = q;
        n.ack = 1'b0;
        case (q.st)
            B_IDLE: begin
                if (req_i) begin
                    n.st    = B_SETUP;
                    n.cnt   = CW'(SETUP_CYC - 1);
                    n.wr    = req_wr_i;
                    n.addr  = req_addr_i;
                    n.dq    = req_data_i;
                    n.dq_oe = req_wr_i;
                end
            end
            B_SETUP: begin
                if (q.cnt == '0) begin
                    n.st   = B_STROBE;
                    n.cnt  = q.wr ? CW'(STROBE_CYC - 1) : CW'(READ_CYC - 1);
                    n.ce_n = 1'b0;
                    n.we_n = ~q.wr;
                    n.oe_n = q.wr;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            B_STROBE: begin
                if (q.cnt == '0) begin
                    n.st   = B_HOLD;
                    n.cnt  = CW'(HOLD_CYC - 1);
                    n.ce_n = 1'b1;
                    n.we_n = 1'b1;
                    n.oe_n = 1'b1;
                    if (!q.wr) begin
                        n.rdata = f_dq_i;
                    end
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            B_HOLD: begin
                if (q.cnt == '0) begin
                    n.st    = B_IDLE;
                    n.ack   = 1'b1;
                    n.dq_oe = 1'b0;
                end else begin
                    n.cnt = q.cnt - 1'b1;
                end
            end
            default: n.st = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= B_IDLE;
            q.ce_n <= 1'b1;
            q.we_n <= 1'b1;
            q.oe_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign ack_o     = q.ack;
    assign rdata_o   = q.rdata;
    assign f_addr_o  = q.addr;
    assign f_dq_o    = q.dq;
    assign f_dq_oe_o = q.dq_oe;
    assign f_ce_n_o  = q.ce_n;
    assign f_we_n_o  = q.we_n;
    assign f_oe_n_o  = q.oe_n;

    // R3
    addr_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.we_n) |-> $stable(q.addr));
    // R3
    data_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.we_n) |-> (q.dq_oe && $stable(q.dq)));
    // R3
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.we_n |-> !q.ce_n);
    // R1
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!q.we_n && !q.oe_n));
    // R2
    req_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> (q.st == B_IDLE));
endmodule

// File: rtl/fbp_sequencer.sv
module fbp_sequencer
    import fbp_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int POLL_LIMIT = 16,
    parameter bit PRE_READ   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        err_code_o,
    output logic              req_o,
    output logic              req_wr_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [7:0]        req_data_o,
    input  logic              ack_i,
    input  logic [7:0]        rdata_i
);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        seq_e              st;
        logic              pend;
        logic [1:0]        step;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [PW-1:0]     polls;
        logic              req;
        logic              req_wr;
        logic [ADDR_W-1:0] req_addr;
        logic [7:0]        req_data;
        logic              done;
        logic              err;
        err_e              code;
    } seq_t;

    seq_t q, n;

    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;

    fbp_cmd_table #(.ADDR_W(ADDR_W)) cmd_i (
        .step_i     (q.step),
        .tgt_addr_i (q.addr),
        .tgt_data_i (q.data),
        .cmd_addr_o (cmd_addr),
        .cmd_data_o (cmd_data)
    );

    always_comb begin
        n      = q;
        n.req  = 1'b0;
        n.done = 1'b0;
        n.err  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    n.addr  = addr_i;
                    n.data  = data_i;
                    n.code  = ERR_NONE;
                    n.polls = '0;
                    n.step  = 2'd0;
                    n.pend  = 1'b0;
                    n.st    = PRE_READ ? S_PRE : S_CMD;
                end
            end
            S_PRE: begin
                if (!q.pend) begin
                    n.req = 1'b1; n.req_wr = 1'b0; n.req_addr = q.addr; n.pend = 1'b1;
                end else if (ack_i) begin
                    n.pend = 1'b0;
                    if ((rdata_i & q.data) != q.data) begin
                        n.err  = 1'b1;
                        n.code = ERR_OVERWRITE;
                        n.st   = S_IDLE;
                    end else begin
                        n.st = S_CMD;
                    end
                end
            end
            S_CMD: begin
                if (!q.pend) begin
                    n.req = 1'b1; n.req_wr = 1'b1; n.pend = 1'b1;
                    n.req_addr = cmd_addr;
                    n.req_data = cmd_data;
                end else if (ack_i) begin
                    n.pend = 1'b0;
                    if (q.step == 2'd3) begin
                        n.st = S_POLL;
                    end else begin
                        n.step = q.step + 2'd1;
                    end
                end
            end
            S_POLL: begin
                if (!q.pend) begin
                    n.req = 1'b1; n.req_wr = 1'b0; n.req_addr = q.addr; n.pend = 1'b1;
                end else if (ack_i) begin
                    n.pend = 1'b0;
                    if (rdata_i[7] == q.data[7]) begin
                        n.st = S_CONF;
                    end else if (q.polls == PW'(POLL_LIMIT - 1)) begin
                        n.st = S_ABORT;
                    end else begin
                        n.polls = q.polls + 1'b1;
                    end
                end
            end
            S_CONF: begin
                if (!q.pend) begin
                    n.req = 1'b1; n.req_wr = 1'b0; n.req_addr = q.addr; n.pend = 1'b1;
                end else if (ack_i) begin
                    n.pend = 1'b0;
                    n.st   = S_IDLE;
                    if (rdata_i == q.data) begin
                        n.done = 1'b1;
                    end else begin
                        n.err  = 1'b1;
                        n.code = ERR_VERIFY;
                    end
                end
            end
            S_ABORT: begin
                if (!q.pend) begin
                    n.req = 1'b1; n.req_wr = 1'b1; n.req_addr = q.addr;
                    n.req_data = RESET_CMD; n.pend = 1'b1;
                end else if (ack_i) begin
                    n.pend = 1'b0;
                    n.err  = 1'b1;
                    n.code = ERR_TIMEOUT;
                    n.st   = S_IDLE;
                end
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.code <= ERR_NONE;
        end else begin
            q <= n;
        end
    end

    assign busy_o     = (q.st != S_IDLE);
    assign done_o     = q.done;
    assign err_o      = q.err;
    assign err_code_o = q.code;
    assign req_o      = q.req;
    assign req_wr_o   = q.req_wr;
    assign req_addr_o = q.req_addr;
    assign req_data_o = q.req_data;

    // R10
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.done && q.err));
    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.polls < PW'(POLL_LIMIT));
    // R9
    tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE) |=> ($stable(q.addr) && $stable(q.data)));
    // R6
    err_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> (q.code != ERR_NONE));
endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl #(
    parameter int ADDR_W     = 20,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1,
    parameter int READ_CYC   = 2,
    parameter int POLL_LIMIT = 16,
    parameter bit PRE_READ   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        err_code_o,
    output logic [ADDR_W-1:0] f_addr_o,
    output logic [7:0]        f_dq_o,
    output logic              f_dq_oe_o,
    input  logic [7:0]        f_dq_i,
    output logic              f_ce_n_o,
    output logic              f_we_n_o,
    output logic              f_oe_n_o
);
    logic              req;
    logic              req_wr;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        req_data;
    logic              ack;
    logic [7:0]        rdata;

    fbp_sequencer #(
        .ADDR_W     (ADDR_W),
        .POLL_LIMIT (POLL_LIMIT),
        .PRE_READ   (PRE_READ)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .err_code_o (err_code_o),
        .req_o      (req),
        .req_wr_o   (req_wr),
        .req_addr_o (req_addr),
        .req_data_o (req_data),
        .ack_i      (ack),
        .rdata_i    (rdata)
    );

    fbp_bus_engine #(
        .ADDR_W     (ADDR_W),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .READ_CYC   (READ_CYC)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .req_wr_i   (req_wr),
        .req_addr_i (req_addr),
        .req_data_i (req_data),
        .ack_o      (ack),
        .rdata_o    (rdata),
        .f_addr_o   (f_addr_o),
        .f_dq_o     (f_dq_o),
        .f_dq_oe_o  (f_dq_oe_o),
        .f_dq_i     (f_dq_i),
        .f_ce_n_o   (f_ce_n_o),
        .f_we_n_o   (f_we_n_o),
        .f_oe_n_o   (f_oe_n_o)
    );
endmodule

// File: tb/fbp_ctrl_tb_top.sv
module fbp_ctrl_tb_top;
    localparam int AW     = 20;
    localparam int STROBE = 3;
    localparam int PLIM   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data = '0;
    logic          busy, done, err;
    logic [1:0]    err_code;
    logic [AW-1:0] f_addr;
    logic [7:0]    f_dq, f_dq_i;
    logic          f_dq_oe, f_ce_n, f_we_n, f_oe_n;

    always #2 clk = ~clk;

    fbp_ctrl #(.ADDR_W(AW), .STROBE_CYC(STROBE), .POLL_LIMIT(PLIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
        .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(err_code),
        .f_addr_o(f_addr), .f_dq_o(f_dq), .f_dq_oe_o(f_dq_oe), .f_dq_i(f_dq_i),
        .f_ce_n_o(f_ce_n), .f_we_n_o(f_we_n), .f_oe_n_o(f_oe_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [AW-1:0] tgt_addr = '0;
    logic [7:0]    mem_val = 8'hFF;
    bit            m_busy = 0, m_hang = 0, m_fault = 0;
    int            busy_reads = 3, busy_left = 0;
    logic [AW-1:0] m_paddr = '0;
    logic [7:0]    m_pdata = '0;
    int            cmd_st = 0, seq_err = 0;
    logic [AW-1:0] wl_addr [0:7];
    logic [7:0]    wl_data [0:7];
    int            wr_cnt = 0, rd_cnt = 0, bad_rd = 0, strobe_bad = 0;
    bit            prev_we = 1, prev_oe = 1;
    int            low_cnt = 0;
    logic [AW-1:0] fall_addr = '0;

    assign f_dq_i = (!f_ce_n && !f_oe_n)
                  ? (m_busy ? {~m_pdata[7], 7'h15}
                            : ((f_addr == tgt_addr) ? mem_val : 8'hFF))
                  : 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_we && !f_we_n) begin
                fall_addr = f_addr;
                low_cnt = 1;
            end else if (!f_we_n) begin
                low_cnt++;
            end
            if (!prev_we && f_we_n) begin
                if (low_cnt != STROBE || f_addr != fall_addr || !f_dq_oe) strobe_bad++;
                if (wr_cnt < 8) begin
                    wl_addr[wr_cnt] = f_addr;
                    wl_data[wr_cnt] = f_dq;
                end
                wr_cnt++;
                if (f_dq == 8'hF0) begin
                    m_busy = 0;
                    cmd_st = 0;
                end else if (!m_busy) begin
                    case (cmd_st)
                        0: if (f_addr == 20'h555 && f_dq == 8'hAA) cmd_st = 1;
                           else seq_err++;
                        1: if (f_addr == 20'h2AA && f_dq == 8'h55) cmd_st = 2;
                           else begin seq_err++; cmd_st = 0; end
                        2: if (f_addr == 20'h555 && f_dq == 8'hA0) cmd_st = 3;
                           else begin seq_err++; cmd_st = 0; end
                        default: begin
                            m_busy = 1; busy_left = busy_reads;
                            m_paddr = f_addr; m_pdata = f_dq; cmd_st = 0;
                        end
                    endcase
                end
            end
            if (!prev_oe && f_oe_n) begin
                rd_cnt++;
                if (f_addr != tgt_addr) bad_rd++;
                if (m_busy && !m_hang) begin
                    busy_left--;
                    if (busy_left <= 0) begin
                        m_busy = 0;
                        if (m_paddr == tgt_addr)
                            mem_val = mem_val & m_pdata & (m_fault ? 8'hFD : 8'hFF);
                    end
                end
            end
            prev_we = f_we_n;
            prev_oe = f_oe_n;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { bit is_err; logic [1:0] code; } evt_t;
    evt_t exp_q[$];
    int   evt_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && (done || err)) begin
            evt_cnt++;
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected completion", {30'd0, err, done}, 0);
            end else begin
                evt_t e;
                e = exp_q.pop_front();
                chk(done == !e.is_err && err == e.is_err, "R10", "completion kind",
                    {31'd0, err}, {31'd0, e.is_err});
                if (e.is_err)
                    chk(err_code == e.code, e.code == 2'd1 ? "R7" : (e.code == 2'd2 ? "R8" : "R6"),
                        "error code", err_code, e.code);
                else
                    chk(err_code == 2'd0, "R5", "code on success", err_code, 0);
            end
        end
    end

    task automatic clear_log();
        wr_cnt = 0; rd_cnt = 0; bad_rd = 0; strobe_bad = 0; seq_err = 0;
    endtask

    task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d,
                          input bit is_err, input logic [1:0] code, input bit extra_start);
        evt_t e;
        int target;
        e.is_err = is_err; e.code = code;
        exp_q.push_back(e);
        target = evt_cnt + 1;
        @(negedge clk);
        start = 1; addr = a; data = d;
        @(negedge clk);
        start = 0;
        // R10 busy follows the accepted start
        chk(busy == 1'b1, "R10", "busy after start", busy, 1);
        if (extra_start) begin
            repeat (10) @(negedge clk);
            start = 1; addr = 20'h00777; data = 8'h00;
            @(negedge clk);
            start = 0;
        end
        while (evt_cnt < target) @(negedge clk);
        @(negedge clk);
        chk(!done && !err && !busy, "R10", "pulse one clock, idle after",
            {29'd0, busy, err, done}, 0);
    endtask

    task automatic check_cmd_seq(input logic [AW-1:0] a, input logic [7:0] d);
        int bad = 0;
        if (wr_cnt != 4) bad++;
        else begin
            if (wl_addr[0] != 20'h555 || wl_data[0] != 8'hAA) bad++;
            if (wl_addr[1] != 20'h2AA || wl_data[1] != 8'h55) bad++;
            if (wl_addr[2] != 20'h555 || wl_data[2] != 8'hA0) bad++;
            if (wl_addr[3] != a || wl_data[3] != d) bad++;
        end
        chk(bad == 0 && seq_err == 0, "R2", "command sequence", wr_cnt, 4);
        chk(strobe_bad == 0, "R3", "write strobe shape", strobe_bad, 0);
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "WD", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err, "R1", "status after reset", {29'd0, busy, done, err}, 0);
        chk(f_ce_n && f_we_n && f_oe_n && !f_dq_oe, "R1", "bus idle in reset",
            {28'd0, f_ce_n, f_we_n, f_oe_n, f_dq_oe}, 4'hE);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(!busy && f_ce_n && f_we_n && f_oe_n, "R1", "idle after reset release",
            {28'd0, busy, f_ce_n, f_we_n, f_oe_n}, 4'h7);

        // A: erased byte, DQ7 target 0, three busy reads
        clear_log(); tgt_addr = 20'h12345; mem_val = 8'hFF; busy_reads = 3;
        run_op(20'h12345, 8'h3C, 0, 2'd0, 0);
        check_cmd_seq(20'h12345, 8'h3C);
        chk(rd_cnt == 6, "R4", "reads pre+4 polls+confirm", rd_cnt, 6);
        chk(bad_rd == 0, "R4", "reads at target", bad_rd, 0);
        chk(mem_val == 8'h3C, "R5", "stored byte", mem_val, 8'h3C);

        // B: DQ7 target 1, top address, one busy read
        clear_log(); tgt_addr = 20'hFFFFF; mem_val = 8'hFF; busy_reads = 1;
        run_op(20'hFFFFF, 8'hA5, 0, 2'd0, 0);
        check_cmd_seq(20'hFFFFF, 8'hA5);
        chk(rd_cnt == 4, "R4", "reads with one busy poll", rd_cnt, 4);
        chk(mem_val == 8'hA5, "R5", "stored byte high bit", mem_val, 8'hA5);

        // C: overwrite refused
        clear_log(); tgt_addr = 20'h00ABC; mem_val = 8'h0F;
        run_op(20'h00ABC, 8'hF0, 1, 2'd1, 0);
        chk(wr_cnt == 0, "R7", "no writes on overwrite", wr_cnt, 0);
        chk(rd_cnt == 1, "R7", "only pre-read", rd_cnt, 1);
        chk(mem_val == 8'h0F, "R7", "memory untouched", mem_val, 8'h0F);

        // D: device never finishes
        clear_log(); tgt_addr = 20'h2AAAA; mem_val = 8'hFF; m_hang = 1;
        run_op(20'h2AAAA, 8'h55, 1, 2'd2, 0);
        chk(rd_cnt == 1 + PLIM, "R8", "poll reads up to limit", rd_cnt, 1 + PLIM);
        chk(wr_cnt == 5 && wl_addr[4] == 20'h2AAAA && wl_data[4] == 8'hF0, "R8",
            "reset write to target", wr_cnt, 5);
        chk(!m_busy, "R8", "device left busy", m_busy, 0);
        m_hang = 0;

        // E: confirm mismatch
        clear_log(); tgt_addr = 20'h00100; mem_val = 8'hFF; m_fault = 1; busy_reads = 2;
        run_op(20'h00100, 8'h5A, 1, 2'd3, 0);
        chk(mem_val == 8'h58, "R6", "faulty store", mem_val, 8'h58);
        chk(rd_cnt == 5, "R6", "confirm read issued", rd_cnt, 5);
        m_fault = 0;

        // F: start while busy ignored
        clear_log(); tgt_addr = 20'h40001; mem_val = 8'hFF; busy_reads = 5;
        run_op(20'h40001, 8'h81, 0, 2'd0, 1);
        check_cmd_seq(20'h40001, 8'h81);
        chk(mem_val == 8'h81, "R9", "original byte stored", mem_val, 8'h81);
        repeat (60) @(negedge clk);
        chk(!busy && wr_cnt == 4 && evt_cnt == 6, "R9", "no second operation", evt_cnt, 6);
        chk(exp_q.size() == 0, "R10", "all completions seen", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule